// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog built on a 10-bit up counter. A count-enable strobe advances the counter once per watchdog tick, so the whole block runs from one system clock. If software does not clear the counter before it passes its top value, the counter wraps to zero and the block raises a one-cycle system reset request. There is no interrupt path. Nothing gates counting during a low-power HALT state, so a HALT that lasts longer than one period ends in a reset.

Software controls the block through a two-register write port. The first register is a 16-bit protection word, and the controls accept writes only while it holds the unlock key 0x0096. The second register is the control word. It holds a 4-bit run code and a write-one clear bit. A run code of 0xA stops the counter, and every other code lets it count. A typical start-up takes four writes: unlock the protection word, set the clear bit, write a run code other than 0xA, then write any other value to the protection word to lock it again.

Top module: `wdt_keyed`

## Requirements
- R1: After reset the run code reads 0xA (stopped), protection is locked, the count is 0 and the reset request is low.
- R2: The protection word takes the value of every write to select 1. The controls are unlocked exactly while that word equals 0x0096, and writing any other value locks them again.
- R3: A control write (select 0) while locked changes neither the run code nor the count.
- R4: While the run code is 0xA the count does not advance. With any other code, each tick adds one.
- R5: Without a tick and without an accepted clear, the count holds its value.
- R6: An accepted control write with bit 4 set clears the count to 0 on that edge. Bits 3:0 of the same write become the new run code. Bit 4 always reads back as 0 in the control readback.
- R7: A tick while running at count 1023 wraps the count to 0 and raises the reset request for exactly one cycle, in the cycle after that edge.
- R8: An accepted clear on the same edge as a would-be overflow wins. The count goes to 0 and no reset request is raised.
- R9: Once running and locked again, the block keeps counting and ignores attempts to stop it until it is unlocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle count-enable strobe per watchdog tick |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control word, 1 protection word |
| wr_data_i | input | 16 | Write data |
| ctrl_rd_o | output | 16 | Control readback: run code in bits 3:0, all other bits 0 |
| unlocked_o | output | 1 | High while the protection word holds the key |
| count_o | output | 10 | Current counter value |
| rst_req_o | output | 1 | One-cycle system reset request on overflow |

## Verification
Every result is due one rising edge after its stimulus:
- A write shows on `ctrl_rd_o` or `unlocked_o` after that one edge.
- A tick or a clear shows on `count_o` after that one edge.
- `rst_req_o` is high in the cycle after the edge at which the count wraps, and low again one edge later.

The bench drives inputs just after a falling edge. It updates its reference model with the inputs present at the next rising edge, then compares all four outputs at the following falling edge. Every check therefore lands exactly one register stage after the stimulus. Whether a write is accepted depends on the protection state before the write edge, and the model uses that same pre-edge state.

// File: rtl/wdt_keyed_pkg.sv
package wdt_keyed_pkg;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_PROT = 1'b1
  } wdt_sel_e;

  localparam int unsigned DEF_CNT_W  = 10;
  localparam int unsigned DEF_RUN_W  = 4;
  localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/wdt_keyed_prot.sv
module wdt_keyed_prot #(
  parameter int unsigned DATA_W     = 16,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h0096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              unlocked_o
);
  logic [DATA_W-1:0] prot_q, prot_d;

  always_comb begin
    prot_d = prot_q;
    if (wr_i) prot_d = data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prot_q <= '0;
    else        prot_q <= prot_d;
  end

  assign unlocked_o = (prot_q == UNLOCK_KEY);
endmodule

// File: rtl/wdt_keyed_ctrl.sv
module wdt_keyed_ctrl #(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned RUN_W     = 4,
  parameter logic [RUN_W-1:0] STOP_CODE = 4'hA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              unlocked_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [RUN_W-1:0]  run_o,
  output logic              running_o,
  output logic              clr_o
);
  localparam int unsigned CLR_BIT = RUN_W;

  logic [RUN_W-1:0] run_q, run_d;
  logic             accept;

  assign accept = wr_i & unlocked_i;

  always_comb begin
    run_d = run_q;
    if (accept) run_d = data_i[RUN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= STOP_CODE;
    else        run_q <= run_d;
  end

  assign run_o     = run_q;
  assign running_o = (run_q != STOP_CODE);
  assign clr_o     = accept & data_i[CLR_BIT];
endmodule

// File: rtl/wdt_keyed_cnt.sv
module wdt_keyed_cnt #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             running_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pulse_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic             step;

  assign step = running_i & tick_i;

  always_comb begin
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr_i) begin
      cnt_d = '0;
    end else if (step) begin
      cnt_d   = cnt_q + 1'b1;
      pulse_d = (cnt_q == CNT_MAX);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign pulse_o = pulse_q;
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_keyed_pkg::*;
#(
  parameter int unsigned CNT_W  = DEF_CNT_W,
  parameter int unsigned RUN_W  = DEF_RUN_W,
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter logic [RUN_W-1:0]  STOP_CODE  = 4'hA,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h0096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] ctrl_rd_o,
  output logic              unlocked_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              rst_req_o
);
  localparam int unsigned PAD_W = DATA_W - RUN_W;

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             wr_ctrl, wr_prot;
  logic             unlocked;
  logic [RUN_W-1:0] run_code;
  logic             running;
  logic             clr_hit;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_ctrl = wr_en_i & (wdt_sel_e'(wr_sel_i) == SEL_CTRL);
  assign wr_prot = wr_en_i & (wdt_sel_e'(wr_sel_i) == SEL_PROT);

  wdt_keyed_prot #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_prot (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (wr_prot),
    .data_i     (wr_data_i),
    .unlocked_o (unlocked)
  );

  wdt_keyed_ctrl #(.DATA_W(DATA_W), .RUN_W(RUN_W), .STOP_CODE(STOP_CODE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_i       (wr_ctrl),
    .unlocked_i (unlocked),
    .data_i     (wr_data_i),
    .run_o      (run_code),
    .running_o  (running),
    .clr_o      (clr_hit)
  );

  wdt_keyed_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .tick_i    (tick_i),
    .running_i (running),
    .clr_i     (clr_hit),
    .cnt_o     (count_o),
    .pulse_o   (rst_req_o)
  );

  assign ctrl_rd_o  = {{PAD_W{1'b0}}, run_code};
  assign unlocked_o = unlocked;
endmodule

// File: rtl/wdt_keyed_chk.sv
module wdt_keyed_chk #(
  parameter int unsigned CNT_W  = 10,
  parameter int unsigned RUN_W  = 4,
  parameter int unsigned DATA_W = 16,
  parameter logic [RUN_W-1:0] STOP_CODE = 4'hA
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              wr_en_i,
  input logic              wr_sel_i,
  input logic [DATA_W-1:0] ctrl_rd_o,
  input logic              unlocked_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              rst_req_o,
  input logic              clr_hit
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o); // R7

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> (count_o == '0)); // R7

  AST_LOCKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked_o && wr_en_i && !wr_sel_i) |=> $stable(ctrl_rd_o)); // R3

  AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_rd_o[RUN_W-1:0] == STOP_CODE) && !clr_hit) |=> $stable(count_o)); // R4

  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clr_hit) |=> $stable(count_o)); // R5

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> (count_o == '0) && !rst_req_o); // R6 R8

  AST_CLEAR_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |-> unlocked_o); // R3
endmodule

bind wdt_keyed wdt_keyed_chk #(
  .CNT_W(CNT_W), .RUN_W(RUN_W), .DATA_W(DATA_W), .STOP_CODE(STOP_CODE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick_i     (tick_i),
  .wr_en_i    (wr_en_i),
  .wr_sel_i   (wr_sel_i),
  .ctrl_rd_o  (ctrl_rd_o),
  .unlocked_o (unlocked_o),
  .count_o    (count_o),
  .rst_req_o  (rst_req_o),
  .clr_hit    (clr_hit)
);

// File: tb/wdt_keyed_test.sv
`timescale 1ns/1ps
module wdt_keyed_test;
  localparam logic [15:0] KEY  = 16'h0096;
  localparam logic [3:0]  STOP = 4'hA;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        tick_i;
  logic        wr_en_i;
  logic        wr_sel_i;
  logic [15:0] wr_data_i;
  logic [15:0] ctrl_rd_o;
  logic        unlocked_o;
  logic [9:0]  count_o;
  logic        rst_req_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model state
  logic [15:0] m_prot;
  logic [3:0]  m_run;
  logic [9:0]  m_cnt;
  logic        m_rst;

  always #10 clk = ~clk;

  wdt_keyed uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_sel_i(wr_sel_i), .wr_data_i(wr_data_i), .ctrl_rd_o(ctrl_rd_o),
    .unlocked_o(unlocked_o), .count_o(count_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  // next state from the requirements, using pre-edge state
  task automatic model_step(input logic t, input logic we, input logic sel, input logic [15:0] d);
    logic unl, acc, clr, run_on;
    unl    = (m_prot == KEY);
    acc    = we && !sel && unl;
    clr    = acc && d[4];
    run_on = (m_run != STOP);
    m_rst  = 1'b0;
    if (clr) m_cnt = '0;
    else if (run_on && t) begin
      m_rst = (m_cnt == 10'h3FF);
      m_cnt = m_cnt + 10'd1;
    end
    if (acc) m_run = d[3:0];
    if (we && sel) m_prot = d;
  endtask

  task automatic cyc(input logic t, input logic we, input logic sel,
                     input logic [15:0] d, input string tag);
    tick_i = t; wr_en_i = we; wr_sel_i = sel; wr_data_i = d;
    @(posedge clk);
    model_step(t, we, sel, d);
    @(negedge clk);
    tick_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = '0;
    chk({tag, " count"}, 32'(count_o), 32'(m_cnt));
    chk({tag, " rstreq"}, 32'(rst_req_o), 32'(m_rst));
    chk({tag, " ctrl_rd"}, 32'(ctrl_rd_o), {28'd0, m_run});
    chk({tag, " unlocked"}, 32'(unlocked_o), 32'(m_prot == KEY));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; tick_i = 0; wr_en_i = 0; wr_sel_i = 0; wr_data_i = '0;
    m_prot = '0; m_run = STOP; m_cnt = '0; m_rst = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 run code", 32'(ctrl_rd_o), 32'h000A);
    chk("R1 locked", 32'(unlocked_o), 0);
    chk("R1 count", 32'(count_o), 0);
    chk("R1 rstreq", 32'(rst_req_o), 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R3: locked control write ignored
    cyc(0, 1, 0, 16'h0015, "R3 locked write");
    chk("R3 run unchanged", 32'(ctrl_rd_o), 32'h000A);
    // R4: stopped, ticks ignored
    for (int i = 0; i < 5; i++) cyc(1, 0, 0, 0, "R4 stopped");
    chk("R4 count still 0", 32'(count_o), 0);
    // R2: unlock
    cyc(0, 1, 1, KEY, "R2 unlock");
    chk("R2 unlocked", 32'(unlocked_o), 1);
    // R6: clear and start with run=3
    cyc(0, 1, 0, 16'h0013, "R6 clear start");
    chk("R6 clear bit reads 0", 32'(ctrl_rd_o), 32'h0003);
    for (int i = 0; i < 7; i++) cyc(1, 0, 0, 0, "R4 counting");
    chk("R4 count 7", 32'(count_o), 7);
    cyc(0, 1, 0, 16'h0013, "R6 clear");
    chk("R6 count cleared", 32'(count_o), 0);
    // R2/R9: relock, stop attempt ignored
    cyc(0, 1, 1, 16'h1234, "R2 relock");
    chk("R2 locked again", 32'(unlocked_o), 0);
    cyc(0, 1, 0, 16'h001A, "R9 stop ignored");
    chk("R9 still running", 32'(ctrl_rd_o), 32'h0003);
    // R5: idle holds
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, "R5 idle");
    // R7: overflow
    for (int i = 0; i < 1023; i++) cyc(1, 0, 0, 0, "R9 run to top");
    chk("R7 at top", 32'(count_o), 32'h3FF);
    cyc(1, 0, 0, 0, "R7 overflow");
    chk("R7 pulse high", 32'(rst_req_o), 1);
    chk("R7 wrapped", 32'(count_o), 0);
    cyc(0, 0, 0, 0, "R7 after pulse");
    chk("R7 pulse one cycle", 32'(rst_req_o), 0);
    // R8: clear beats overflow
    cyc(0, 1, 1, KEY, "R8 unlock");
    for (int i = 0; i < 1023; i++) cyc(1, 0, 0, 0, "R8 run to top");
    cyc(1, 1, 0, 16'h0013, "R8 clear at top");
    chk("R8 no pulse", 32'(rst_req_o), 0);
    chk("R8 count zero", 32'(count_o), 0);
    // R4: stop with code A
    cyc(0, 1, 0, 16'h000A, "R4 stop");
    for (int i = 0; i < 6; i++) cyc(1, 0, 0, 0, "R4 stopped again");
    chk("R4 stopped count", 32'(count_o), 0);

    // constrained random mix
    for (int i = 0; i < 6000; i++) begin
      logic t, we, sel;
      logic [15:0] d;
      t   = ($urandom % 100) < 60;
      we  = ($urandom % 100) < 6;
      sel = $urandom % 2;
      if (sel) d = (($urandom % 2) != 0) ? KEY : 16'($urandom);
      else begin
        d = 16'($urandom);
        if (($urandom % 4) == 0) d[3:0] = STOP;
        if (($urandom % 3) != 0) d[4] = 1'b0;
      end
      cyc(t, we, sel, d, "R2 R3 R4 R5 R6 random");
    end
    finish_run();
  end
endmodule